// File: doc/BRIEF.md
# Nibble Stack Context Saver

This unit owns a downward-growing stack that lives in the first 256 nibbles of data memory, which is memory bank 0. A subroutine call or an interrupt makes it save a context frame: the 14-bit program counter and the 8-bit status word, written one 4-bit nibble per cycle. A return reads the same frame back and rebuilds both values. A second, shorter frame saves or restores the pair of bank selectors: the 4-bit data memory bank and the register bank.

The stack pointer is 8 bits wide. Software can read it and can write it while the unit is idle. Saving pre-decrements the pointer before each nibble is written. Restoring reads the nibble at the pointer and then post-increments it. Both wrap modulo 256, so the stack never leaves bank 0, whatever memory bank the rest of the core has selected. With the pointer at 00H, the first saved nibble lands at 0FFH.

A request is accepted in a cycle when the unit is idle. The inputs are captured in that cycle, and the unit then holds `busy` high for the whole frame. One cycle after the last nibble, with `busy` low again, it pulses `done`. The memory is assumed to read combinationally: `mem_rdata` reflects `mem_addr` within the same cycle.

Top module: `ctx_stack`

## Requirements
- R1: After reset the stack pointer reads 00H. While idle, `sp_wr_en` loads `sp_wr_data` with bit 0 forced to 0. When the unit is idle, the pointer is always even.
- R2: A call frame writes 6 nibbles in consecutive cycles, at SP-1, SP-2, … SP-6, in this order: PC[3:0], PC[7:4], PC[11:8], {2'b00, PC[13:12]}, status[3:0], status[7:4]. The pointer ends 6 lower.
- R3: A return reads 6 nibbles at SP, SP+1, … SP+5. It rebuilds status = {m[SP], m[SP+1]} and PC = {m[SP+2][1:0], m[SP+3], m[SP+4], m[SP+5]}. The pointer ends 6 higher.
- R4: A bank save writes the data-memory bank select at SP-1, then the register bank select at SP-2. The pointer ends 2 lower.
- R5: A bank restore reads the register bank select from SP and the data-memory bank select from SP+1. The pointer ends 2 higher.
- R6: Every stack access has address bits [11:8] equal to 0. Pointer arithmetic wraps modulo 256, so a save from SP=00H writes first at 0FFH.
- R7: `busy` is high for exactly the frame length (6 or 2 cycles), starting the cycle after acceptance. `done` is high for the single cycle that follows, with `busy` low. The restored outputs are valid in that cycle.
- R8: While busy, new requests and pointer writes are ignored. The frame length and the final pointer show no trace of them.
- R9: When several requests arrive together, call has the highest priority, then return, then bank save, then bank restore. A pointer write in the same idle cycle wins, and the requests in that cycle are dropped.
- R10: PC, status and bank selects are taken in the accepting cycle. Changes to them during the frame do not alter the written nibbles.
- R11: Write enable is high only on save cycles and read enable only on restore cycles, never both at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_call | input | 1 | Save a call or interrupt frame |
| req_ret | input | 1 | Restore a call or interrupt frame |
| req_bank_save | input | 1 | Save the bank-select pair |
| req_bank_load | input | 1 | Restore the bank-select pair |
| sp_wr_en | input | 1 | Load the stack pointer (idle only) |
| sp_wr_data | input | 8 | New stack pointer value |
| pc_in | input | 14 | Program counter to save |
| stat_in | input | 8 | Status word to save |
| dbank_in | input | 4 | Data memory bank select to save |
| rbank_in | input | 4 | Register bank select to save |
| mem_rdata | input | 4 | Nibble read from data memory |
| mem_addr | output | 12 | Data memory nibble address |
| mem_wdata | output | 4 | Nibble to write |
| mem_we | output | 1 | Write strobe |
| mem_re | output | 1 | Read strobe |
| sp_value | output | 8 | Current stack pointer |
| pc_out | output | 14 | Restored program counter |
| stat_out | output | 8 | Restored status word |
| dbank_out | output | 4 | Restored data memory bank select |
| rbank_out | output | 4 | Restored register bank select |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle end-of-frame pulse |

## Verification
The assertions take two things for granted about the inputs. The memory answers reads in the same cycle. A restore reads whatever the stack holds, so it expects no particular pairing with an earlier save. The walk checks also assume that two frames never run back to back without an idle cycle between them. The design guarantees that gap itself through the `done` cycle. The stimulus drives requests one cycle wide on the falling edge. Any disturbance it injects (extra requests, pointer writes, changed context inputs) is placed only in the early frame cycles and cleared before `done`. Restores are checked against an expected image of memory that the bench builds from its own save predictions, so a restore that follows a bank save of a different shape is still predictable.

// File: rtl/ctx_stack_pkg.sv
// Package: shared operation type and helpers for the nibble stack context saver.
// Assumes: four operations only; call and interrupt share one frame shape.
package ctx_stack_pkg;

    typedef enum logic [1:0] {
        OP_CALL      = 2'd0,
        OP_RET       = 2'd1,
        OP_BANK_SAVE = 2'd2,
        OP_BANK_LOAD = 2'd3
    } stk_op_e;

    // True for operations that write to the stack.
    function automatic logic op_writes(input stk_op_e op);
        return (op == OP_CALL) || (op == OP_BANK_SAVE);
    endfunction

    // True for operations that move the program-counter/status frame.
    function automatic logic op_is_ctx(input stk_op_e op);
        return (op == OP_CALL) || (op == OP_RET);
    endfunction

endpackage

// File: rtl/ctx_stack_ptr.sv
// Module: stack pointer register.
// Holds the pointer, accepts an even-forced software load,
// and steps by one nibble in either direction. Wraps modulo 2**SP_W.
// Assumes: at most one of load/dec/inc is active per cycle (load wins).
module ctx_stack_ptr #(
    parameter int SP_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load_en,
    input  logic [SP_W-1:0] load_val,
    input  logic            dec_en,
    input  logic            inc_en,
    output logic [SP_W-1:0] sp
);

    // Pointer update: load with bit 0 cleared, or step one nibble.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sp <= '0;
        else if (load_en)
            sp <= {load_val[SP_W-1:1], 1'b0};
        else if (dec_en)
            sp <= sp - SP_W'(1);
        else if (inc_en)
            sp <= sp + SP_W'(1);
    end

    AST_LOAD_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> (sp[0] == 1'b0)); // R1

endmodule

// File: rtl/ctx_stack_seq.sv
// Module: frame sequencer.
// Arbitrates requests by fixed priority, then steps through one nibble per
// cycle for the frame length and raises done one cycle after the last step.
// Assumes: requests are sampled only when idle; a pointer write blocks acceptance.
module ctx_stack_seq
    import ctx_stack_pkg::*;
#(
    parameter int CTX_NIBS = 6,
    parameter int BANK_NIBS = 2,
    parameter int STEP_W = $clog2(CTX_NIBS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_call,
    input  logic              req_ret,
    input  logic              req_bank_save,
    input  logic              req_bank_load,
    input  logic              sp_wr,
    output logic              busy,
    output logic              done,
    output logic              start,
    output stk_op_e           op_sel,
    output stk_op_e           op,
    output logic [STEP_W-1:0] step,
    output logic              last
);

    localparam logic [STEP_W-1:0] CTX_LAST  = STEP_W'(CTX_NIBS - 1);
    localparam logic [STEP_W-1:0] BANK_LAST = STEP_W'(BANK_NIBS - 1);

    logic any_req;

    // Fixed-priority choice among simultaneous requests.
    always_comb begin
        if (req_call)           op_sel = OP_CALL;
        else if (req_ret)       op_sel = OP_RET;
        else if (req_bank_save) op_sel = OP_BANK_SAVE;
        else                    op_sel = OP_BANK_LOAD;
    end

    // Acceptance and end-of-frame detection.
    always_comb begin
        any_req = req_call | req_ret | req_bank_save | req_bank_load;
        start   = !busy && !sp_wr && any_req;
        last    = busy && (step == (op_is_ctx(op) ? CTX_LAST : BANK_LAST));
    end

    // Frame state: busy flag, step counter, latched operation, done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            done <= 1'b0;
            step <= '0;
            op   <= OP_CALL;
        end else begin
            done <= last;
            if (start) begin
                busy <= 1'b1;
                step <= '0;
                op   <= op_sel;
            end else if (last) begin
                busy <= 1'b0;
                step <= '0;
            end else if (busy) begin
                step <= step + STEP_W'(1);
            end
        end
    end

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R7
    AST_STEP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !op_is_ctx(op)) |-> (step <= BANK_LAST)); // R7
    AST_OP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(op)); // R8

endmodule

// File: rtl/ctx_stack_frame.sv
// Module: frame datapath.
// Captures the context at acceptance, serves the nibble for each save step,
// and shifts restored nibbles into a buffer that feeds the output registers
// on the final step.
// Assumes: read data is valid in the same cycle as the address.
module ctx_stack_frame
    import ctx_stack_pkg::*;
#(
    parameter int PC_W   = 14,
    parameter int STAT_W = 8,
    parameter int NIB_W  = 4,
    parameter int CTX_NIBS = 6,
    parameter int STEP_W = $clog2(CTX_NIBS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  stk_op_e           op_sel,
    input  stk_op_e           op,
    input  logic              busy,
    input  logic              last,
    input  logic [STEP_W-1:0] step,
    input  logic [PC_W-1:0]   pc_in,
    input  logic [STAT_W-1:0] stat_in,
    input  logic [NIB_W-1:0]  dbank_in,
    input  logic [NIB_W-1:0]  rbank_in,
    input  logic [NIB_W-1:0]  rd_nib,
    output logic [NIB_W-1:0]  wr_nib,
    output logic [PC_W-1:0]   pc_out,
    output logic [STAT_W-1:0] stat_out,
    output logic [NIB_W-1:0]  dbank_out,
    output logic [NIB_W-1:0]  rbank_out
);

    localparam int PC_NIBS = (PC_W + NIB_W - 1) / NIB_W;
    localparam int PC_PAD  = PC_NIBS * NIB_W;
    localparam int FRAME_W = CTX_NIBS * NIB_W;

    logic [FRAME_W-1:0] snap;
    logic [FRAME_W-1:0] rbuf;
    logic [FRAME_W-1:0] rbuf_nxt;
    logic               rd_en;

    // Snapshot of the frame contents, lowest nibble saved first.
    always_ff @(posedge clk) begin
        if (!rst_n)
            snap <= '0;
        else if (start && op_writes(op_sel)) begin
            if (op_is_ctx(op_sel))
                snap <= {stat_in, PC_PAD'(pc_in)};
            else
                snap <= FRAME_W'({rbank_in, dbank_in});
        end
    end

    // Nibble for the current save step.
    always_comb begin
        wr_nib   = snap[int'(step) * NIB_W +: NIB_W];
        rd_en    = busy && !op_writes(op);
        rbuf_nxt = {rbuf[FRAME_W-NIB_W-1:0], rd_nib};
    end

    // Restore buffer: the first nibble read ends at the top.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rbuf <= '0;
        else if (rd_en)
            rbuf <= rbuf_nxt;
    end

    // Output registers, loaded from the buffer on the last restore step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_out    <= '0;
            stat_out  <= '0;
            dbank_out <= '0;
            rbank_out <= '0;
        end else if (rd_en && last) begin
            if (op_is_ctx(op)) begin
                pc_out   <= rbuf_nxt[PC_W-1:0];
                stat_out <= rbuf_nxt[FRAME_W-1 -: STAT_W];
            end else begin
                dbank_out <= rbuf_nxt[NIB_W-1:0];
                rbank_out <= rbuf_nxt[2*NIB_W-1:NIB_W];
            end
        end
    end

    AST_SNAP_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(snap)); // R10

endmodule

// File: rtl/ctx_stack.sv
// Module: nibble stack context saver (top).
// Saves and restores the program-counter/status frame and the bank-select
// pair on a stack fixed to memory bank 0, one nibble per cycle.
// Assumes: combinational memory read; requests are honoured only when idle.
module ctx_stack
    import ctx_stack_pkg::*;
#(
    parameter int PC_W   = 14,
    parameter int STAT_W = 8,
    parameter int NIB_W  = 4,
    parameter int SP_W   = 8,
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_call,
    input  logic              req_ret,
    input  logic              req_bank_save,
    input  logic              req_bank_load,
    input  logic              sp_wr_en,
    input  logic [SP_W-1:0]   sp_wr_data,
    input  logic [PC_W-1:0]   pc_in,
    input  logic [STAT_W-1:0] stat_in,
    input  logic [NIB_W-1:0]  dbank_in,
    input  logic [NIB_W-1:0]  rbank_in,
    input  logic [NIB_W-1:0]  mem_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [NIB_W-1:0]  mem_wdata,
    output logic              mem_we,
    output logic              mem_re,
    output logic [SP_W-1:0]   sp_value,
    output logic [PC_W-1:0]   pc_out,
    output logic [STAT_W-1:0] stat_out,
    output logic [NIB_W-1:0]  dbank_out,
    output logic [NIB_W-1:0]  rbank_out,
    output logic              busy,
    output logic              done
);

    localparam int PC_NIBS   = (PC_W + NIB_W - 1) / NIB_W;
    localparam int CTX_NIBS  = PC_NIBS + STAT_W / NIB_W;
    localparam int BANK_NIBS = 2;
    localparam int STEP_W    = $clog2(CTX_NIBS);

    logic              start;
    logic              last;
    stk_op_e           op_sel;
    stk_op_e           op;
    logic [STEP_W-1:0] step;
    logic [SP_W-1:0]   sp;
    logic [SP_W-1:0]   addr_lo;
    logic              sp_load;

    ctx_stack_seq #(
        .CTX_NIBS  (CTX_NIBS),
        .BANK_NIBS (BANK_NIBS),
        .STEP_W    (STEP_W)
    ) seq_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_call      (req_call),
        .req_ret       (req_ret),
        .req_bank_save (req_bank_save),
        .req_bank_load (req_bank_load),
        .sp_wr         (sp_wr_en),
        .busy          (busy),
        .done          (done),
        .start         (start),
        .op_sel        (op_sel),
        .op            (op),
        .step          (step),
        .last          (last)
    );

    // Memory strobes and bank-0 address: saves use SP-1, restores use SP.
    always_comb begin
        mem_we   = busy && op_writes(op);
        mem_re   = busy && !op_writes(op);
        sp_load  = sp_wr_en && !busy;
        addr_lo  = mem_we ? (sp - SP_W'(1)) : sp;
        mem_addr = {{(ADDR_W - SP_W){1'b0}}, addr_lo};
        sp_value = sp;
    end

    ctx_stack_ptr #(.SP_W(SP_W)) ptr_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_en  (sp_load),
        .load_val (sp_wr_data),
        .dec_en   (mem_we),
        .inc_en   (mem_re),
        .sp       (sp)
    );

    ctx_stack_frame #(
        .PC_W     (PC_W),
        .STAT_W   (STAT_W),
        .NIB_W    (NIB_W),
        .CTX_NIBS (CTX_NIBS),
        .STEP_W   (STEP_W)
    ) frame_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .op_sel    (op_sel),
        .op        (op),
        .busy      (busy),
        .last      (last),
        .step      (step),
        .pc_in     (pc_in),
        .stat_in   (stat_in),
        .dbank_in  (dbank_in),
        .rbank_in  (rbank_in),
        .rd_nib    (mem_rdata),
        .wr_nib    (mem_wdata),
        .pc_out    (pc_out),
        .stat_out  (stat_out),
        .dbank_out (dbank_out),
        .rbank_out (rbank_out)
    );

    AST_SP_EVEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (sp_value[0] == 1'b0)); // R1
    AST_SAVE_WALK: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && $past(mem_we)) |->
            (mem_addr[SP_W-1:0] == $past(mem_addr[SP_W-1:0]) - SP_W'(1))); // R2
    AST_LOAD_WALK: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_re && $past(mem_re)) |->
            (mem_addr[SP_W-1:0] == $past(mem_addr[SP_W-1:0]) + SP_W'(1))); // R3
    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we && mem_re)); // R11
    AST_DONE_AFTER: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy))); // R7
    AST_BUSY_SP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && $past(!busy) && !$past(sp_wr_en)) |-> $stable(sp_value)); // R8

endmodule

// File: tb/ctx_stack_tb_top.sv
// Bench: directed corner cases plus seeded random frames, checked against a
// bench-side pointer and memory image.
module ctx_stack_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_call = 0, req_ret = 0, req_bank_save = 0, req_bank_load = 0;
    logic        sp_wr_en = 0;
    logic [7:0]  sp_wr_data = '0;
    logic [13:0] pc_in = '0;
    logic [7:0]  stat_in = '0;
    logic [3:0]  dbank_in = '0, rbank_in = '0;
    logic [3:0]  mem_rdata;
    logic [11:0] mem_addr;
    logic [3:0]  mem_wdata;
    logic        mem_we, mem_re;
    logic [7:0]  sp_value;
    logic [13:0] pc_out;
    logic [7:0]  stat_out;
    logic [3:0]  dbank_out, rbank_out;
    logic        busy, done;

    logic [3:0]  mem [256];
    logic [3:0]  exp_mem [256];
    logic [7:0]  exp_sp;
    int          n_chk = 0;
    int          n_fail = 0;
    int          cyc = 0;
    bit          ended = 0;

    always #10 clk = ~clk;

    ctx_stack dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_call(req_call), .req_ret(req_ret),
        .req_bank_save(req_bank_save), .req_bank_load(req_bank_load),
        .sp_wr_en(sp_wr_en), .sp_wr_data(sp_wr_data),
        .pc_in(pc_in), .stat_in(stat_in), .dbank_in(dbank_in), .rbank_in(rbank_in),
        .mem_rdata(mem_rdata), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_we(mem_we), .mem_re(mem_re), .sp_value(sp_value),
        .pc_out(pc_out), .stat_out(stat_out), .dbank_out(dbank_out),
        .rbank_out(rbank_out), .busy(busy), .done(done)
    );

    assign mem_rdata = mem[mem_addr[7:0]];
    always @(posedge clk) if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;

    task automatic finish_run();
        ended = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !ended) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%0d expected<150000", cyc);
            finish_run();
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    // op: 0 call, 1 return, 2 bank save, 3 bank restore; extra = other requests raised too.
    task automatic run_op(input int op, input logic [3:0] extra, input logic [13:0] pc,
                          input logic [7:0] st, input logic [3:0] db, input logic [3:0] rb,
                          input bit disturb);
        int n;
        logic [23:0] vec;
        logic [7:0]  base;
        logic [7:0]  a;
        string       rq;
        n    = (op < 2) ? 6 : 2;
        vec  = (op == 0) ? {st, 2'b00, pc} : {16'h0, rb, db};
        base = exp_sp;
        rq   = (op == 0) ? "R2" : (op == 1) ? "R3" : (op == 2) ? "R4" : "R5";
        @(negedge clk);
        pc_in = pc; stat_in = st; dbank_in = db; rbank_in = rb;
        req_call = (op == 0) | extra[0];
        req_ret = (op == 1) | extra[1];
        req_bank_save = (op == 2) | extra[2];
        req_bank_load = (op == 3) | extra[3];
        @(negedge clk);
        req_call = 0; req_ret = 0; req_bank_save = 0; req_bank_load = 0;
        for (int k = 0; k < n; k++) begin
            if (disturb && k == 0) begin
                req_call = 1; req_bank_load = 1; sp_wr_en = 1;
                sp_wr_data = 8'($urandom);
                pc_in = 14'($urandom); stat_in = 8'($urandom);
                dbank_in = 4'($urandom); rbank_in = 4'($urandom);
            end
            if (disturb && k == 1) begin
                req_call = 0; req_bank_load = 0; sp_wr_en = 0;
            end
            chk(busy == 1'b1, "R7 busy in frame", {31'd0, busy}, 1);
            if (op == 0 || op == 2) begin
                a = base - 8'(k + 1);
                chk(mem_we && !mem_re, "R11 save strobes", {30'd0, mem_we, mem_re}, 2);
                chk(mem_addr == {4'h0, a}, {rq, " R6 save address"}, {20'd0, mem_addr}, {24'd0, a});
                chk(mem_wdata == vec[4*k +: 4], {rq, " R10 save nibble"}, {28'd0, mem_wdata}, {28'd0, vec[4*k +: 4]});
                exp_mem[a] = vec[4*k +: 4];
            end else begin
                a = base + 8'(k);
                chk(mem_re && !mem_we, "R11 restore strobes", {30'd0, mem_we, mem_re}, 1);
                chk(mem_addr == {4'h0, a}, {rq, " R6 restore address"}, {20'd0, mem_addr}, {24'd0, a});
            end
            @(negedge clk);
        end
        chk(done && !busy, "R7 done pulse", {30'd0, done, busy}, 2);
        exp_sp = (op == 0 || op == 2) ? base - 8'(n) : base + 8'(n);
        chk(sp_value == exp_sp, {rq, " R8 final pointer"}, {24'd0, sp_value}, {24'd0, exp_sp});
        if (op == 1) begin
            logic [13:0] epc;
            logic [7:0]  est;
            est = {exp_mem[base], exp_mem[8'(base + 1)]};
            epc = {exp_mem[8'(base + 2)][1:0], exp_mem[8'(base + 3)],
                   exp_mem[8'(base + 4)], exp_mem[8'(base + 5)]};
            chk(pc_out == epc, "R3 restored pc", {18'd0, pc_out}, {18'd0, epc});
            chk(stat_out == est, "R3 restored status", {24'd0, stat_out}, {24'd0, est});
        end else if (op == 3) begin
            chk(rbank_out == exp_mem[base], "R5 restored rbank", {28'd0, rbank_out}, {28'd0, exp_mem[base]});
            chk(dbank_out == exp_mem[8'(base + 1)], "R5 restored dbank", {28'd0, dbank_out}, {28'd0, exp_mem[8'(base + 1)]});
        end
        @(negedge clk);
        chk(!done && !busy, "R7 done single", {30'd0, done, busy}, 0);
    endtask

    task automatic write_sp(input logic [7:0] v);
        @(negedge clk);
        sp_wr_en = 1; sp_wr_data = v;
        @(negedge clk);
        sp_wr_en = 0;
        exp_sp = {v[7:1], 1'b0};
        chk(sp_value == exp_sp, "R1 pointer load even", {24'd0, sp_value}, {24'd0, exp_sp});
    endtask

    initial begin
        for (int i = 0; i < 256; i++) begin mem[i] = '0; exp_mem[i] = '0; end
        exp_sp = '0;
        void'($urandom(32'd2718));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(sp_value == 8'h00, "R1 reset pointer", {24'd0, sp_value}, 0);
        chk(!busy && !done && !mem_we && !mem_re, "R1 reset idle", {28'd0, busy, done, mem_we, mem_re}, 0);
        chk(pc_out == '0 && stat_out == '0, "R1 reset outputs", {10'd0, pc_out, stat_out}, 0);

        write_sp(8'h13);
        write_sp(8'h00);
        // R6: save from 00H lands at 0FFH and wraps.
        run_op(0, 4'b0000, 14'h2A5C, 8'hB7, 4'h0, 4'h0, 0);
        run_op(1, 4'b0000, 14'h0, 8'h0, 4'h0, 4'h0, 0);
        chk(pc_out == 14'h2A5C, "R3 directed pc", {18'd0, pc_out}, 32'h2A5C);
        run_op(2, 4'b0000, 14'h0, 8'h0, 4'hF, 4'h3, 0);
        run_op(3, 4'b0000, 14'h0, 8'h0, 4'h0, 4'h0, 0);
        chk(dbank_out == 4'hF && rbank_out == 4'h3, "R5 directed banks", {24'd0, rbank_out, dbank_out}, 32'h3F);
        // R9 priority checks.
        run_op(0, 4'b1110, 14'h1234, 8'h5A, 4'h1, 4'h2, 0);
        run_op(1, 4'b1100, 14'h0, 8'h0, 4'h0, 4'h0, 0);
        run_op(2, 4'b1000, 14'h0, 8'h0, 4'h6, 4'h9, 0);
        run_op(3, 4'b0000, 14'h0, 8'h0, 4'h0, 4'h0, 0);
        // R9: pointer write beats a request in the same cycle.
        @(negedge clk);
        sp_wr_en = 1; sp_wr_data = 8'h41; req_ret = 1;
        @(negedge clk);
        sp_wr_en = 0; req_ret = 0;
        exp_sp = 8'h40;
        chk(!busy && sp_value == 8'h40, "R9 write beats request", {23'd0, busy, sp_value}, 32'h40);
        @(negedge clk);
        chk(!busy, "R9 request dropped", {31'd0, busy}, 0);
        // R8 and R10: disturbances during frames.
        run_op(0, 4'b0000, 14'h3FFF, 8'hFF, 4'h0, 4'h0, 1);
        run_op(2, 4'b0000, 14'h0, 8'h0, 4'hA, 4'h5, 1);
        run_op(3, 4'b0000, 14'h0, 8'h0, 4'h0, 4'h0, 1);
        run_op(1, 4'b0000, 14'h0, 8'h0, 4'h0, 4'h0, 1);
        chk(pc_out == 14'h3FFF && stat_out == 8'hFF, "R10 captured context", {10'd0, pc_out, stat_out}, 32'h3FFFFF);

        for (int t = 0; t < 400; t++) begin
            int op;
            op = int'($urandom_range(0, 4));
            if (op == 4)
                write_sp(8'($urandom));
            else
                run_op(op, 4'($urandom) & 4'($urandom) & ~(4'b0001 << op) & ~((4'b0001 << op) - 4'd1),
                       14'($urandom), 8'($urandom), 4'($urandom), 4'($urandom),
                       ($urandom_range(0, 3) == 0));
        end
        finish_run();
    end

endmodule